// File: doc/BRIEF.md
# Multi-polynomial CRC calculator

This block computes a running cyclic redundancy check over words that software writes one at a time through a small register port. At run time a control word picks one of four generator polynomials and one of three input widths. It also switches on two transforms for the incoming word, bit reversal inside each byte and inversion. Two more transforms apply to the result, reversal across the active polynomial width and inversion. Each accepted data write folds into the remainder in a single clock cycle.

Software first writes a seed, then writes the control word with the engine-reset bit set. That loads the seed as the starting remainder. Software then writes the data words and reads the checksum. The reset bit is not stored, and the other control fields keep the values written with it. Data writes made while the enable bit is clear leave the remainder untouched.

Top module: `multipoly_crc`

## Requirements
- R1: Control bits [9:8] select the polynomial. 0 is the 16-bit CCITT polynomial 0x1021, 1 is the 8-bit polynomial 0x07, 2 is the 16-bit polynomial 0x8005 and 3 is the 32-bit polynomial 0x04C11DB7. Data bits enter most significant bit first, so a zero remainder fed the single value 1 yields the polynomial's low bits.
- R2: Control bits [7:6] select the input width. 0 uses only data[7:0], 1 uses only data[15:0], 2 uses all 32 bits, and the reserved code 3 also uses all 32 bits.
- R3: When control bit 2 is set, each byte of the data word is bit-reversed in place before use, so 0xAABBCCDD is processed as 0x55DD33BB.
- R4: When control bit 4 is set, the data word is inverted before use.
- R5: When control bit 3 is set, the checksum is bit-reversed across the active polynomial width. For example, a 32-bit remainder 0x04C11DB7 reads 0xEDB88320 and an 8-bit remainder 0x07 reads 0xE0.
- R6: When control bit 5 is set, the checksum is inverted within the active width. In every mode, bits above the active width read as zero.
- R7: Writing the control word with bit 1 set loads the stored seed, masked to the newly selected width, as the remainder. Bit 1 reads back as 0, and the other written fields read back unchanged.
- R8: When control bit 0 (enable) is clear, data writes do not change the checksum.
- R9: The checksum reflects a data write on the first clock edge after it, and it stays stable in cycles with no write.
- R10: After hardware reset the control word, the seed and the checksum all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 data, 2 seed, 3 none |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read source: 0 control, 1 checksum, 2 seed, 3 zero |
| rd_data | output | 32 | Selected read value (combinational) |
| checksum_o | output | 32 | Transformed checksum |

## Verification
The bench builds the block with its default 32-bit data path, which is the only width the four polynomial lanes and the byte-wise reversal are laid out for. With that width, the reserved length code and the 32-bit polynomial are both reachable. Known-answer words check each polynomial, width and transform directly. A random sweep across every mode, length and transform combination, with seed reloads and mode changes in between, is then compared against a bitwise model on every clock.

// File: rtl/mpcrc_pkg.sv
package mpcrc_pkg;

    localparam int DW     = 32;
    localparam int NMODES = 4;

    typedef enum logic [1:0] {MODE_CCITT = 2'd0, MODE_C8 = 2'd1, MODE_C16 = 2'd2, MODE_C32 = 2'd3} crc_mode_e;
    typedef enum logic [1:0] {LEN_B8 = 2'd0, LEN_B16 = 2'd1, LEN_B32 = 2'd2, LEN_RSV = 2'd3} data_len_e;
    typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_DATA = 2'd1, SEL_SEED = 2'd2, SEL_NONE = 2'd3} port_sel_e;

    typedef struct packed {
        crc_mode_e mode;
        data_len_e len;
        logic      out_inv;
        logic      in_inv;
        logic      out_rev;
        logic      in_rev;
        logic      en;
    } ctrl_t;

    function automatic int mode_width(int m);
        case (m)
            1:       return 8;
            3:       return 32;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] mode_poly(int m);
        case (m)
            0:       return 32'h0000_1021;
            1:       return 32'h0000_0007;
            2:       return 32'h0000_8005;
            default: return 32'h04C1_1DB7;
        endcase
    endfunction

    function automatic logic [31:0] mode_mask(crc_mode_e m);
        case (m)
            MODE_C8:  return 32'h0000_00FF;
            MODE_C32: return 32'hFFFF_FFFF;
            default:  return 32'h0000_FFFF;
        endcase
    endfunction

    function automatic int len_bits(data_len_e l);
        case (l)
            LEN_B8:  return 8;
            LEN_B16: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic ctrl_t decode_ctrl(logic [31:0] w);
        ctrl_t c;
        c.en      = w[0];
        c.in_rev  = w[2];
        c.out_rev = w[3];
        c.in_inv  = w[4];
        c.out_inv = w[5];
        c.len     = data_len_e'(w[7:6]);
        c.mode    = crc_mode_e'(w[9:8]);
        return c;
    endfunction

endpackage

// File: rtl/mpcrc_in_shape.sv
module mpcrc_in_shape #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] data_i,
    input  logic          rev_i,
    input  logic          inv_i,
    output logic [DW-1:0] data_o
);
    localparam int NBYTES = DW / 8;

    logic [DW-1:0] swapped;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign swapped[b*8 + i] = data_i[b*8 + 7 - i];
        end
    end

    always_comb begin
        data_o = rev_i ? swapped : data_i;
        if (inv_i) begin
            data_o = ~data_o;
        end
    end
endmodule

// File: rtl/mpcrc_lane.sv
module mpcrc_lane #(
    parameter int          DW   = 32,
    parameter int          W    = 16,
    parameter logic [31:0] POLY = 32'h0000_1021
) (
    input  logic [DW-1:0]         crc_i,
    input  logic [DW-1:0]         data_i,
    input  mpcrc_pkg::data_len_e  len_i,
    output logic [DW-1:0]         crc_o
);
    always_comb begin
        logic [W-1:0] c;
        logic         fb;
        int           nb;
        nb = mpcrc_pkg::len_bits(len_i);
        c  = crc_i[W-1:0];
        fb = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (i < nb) begin
                fb = c[W-1] ^ data_i[i];
                c  = {c[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : {W{1'b0}});
            end
        end
        crc_o        = '0;
        crc_o[W-1:0] = c;
    end
endmodule

// File: rtl/mpcrc_out_shape.sv
module mpcrc_out_shape #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]         raw_i,
    input  mpcrc_pkg::crc_mode_e  mode_i,
    input  logic                  rev_i,
    input  logic                  inv_i,
    output logic [DW-1:0]         sum_o
);
    always_comb begin
        logic [DW-1:0] m;
        logic [DW-1:0] v;
        logic [DW-1:0] r;
        int            w;
        w = mpcrc_pkg::mode_width(int'(mode_i));
        m = mpcrc_pkg::mode_mask(mode_i);
        v = raw_i & m;
        r = '0;
        for (int i = 0; i < DW; i++) begin
            for (int j = 0; j < DW; j++) begin
                if (i < w && j == w - 1 - i) begin
                    r[i] = v[j];
                end
            end
        end
        if (rev_i) begin
            v = r;
        end
        if (inv_i) begin
            v = ~v & m;
        end
        sum_o = v;
    end
endmodule

// File: rtl/multipoly_crc.sv
module multipoly_crc #(
    parameter int DW = mpcrc_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] checksum_o
);
    import mpcrc_pkg::*;

    localparam int NM = NMODES;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] seed;
        logic [DW-1:0] crc;
    } state_t;

    state_t        st_d, st_q;
    logic [DW-1:0] shaped_data;
    logic [DW-1:0] lane_res [NM];
    ctrl_t         wr_ctrl;

    mpcrc_in_shape #(.DW(DW)) u_in (
        .data_i (wr_data),
        .rev_i  (st_q.ctrl.in_rev),
        .inv_i  (st_q.ctrl.in_inv),
        .data_o (shaped_data)
    );

    for (genvar g = 0; g < NM; g++) begin : g_lane
        mpcrc_lane #(
            .DW   (DW),
            .W    (mode_width(g)),
            .POLY (mode_poly(g))
        ) u_lane (
            .crc_i  (st_q.crc),
            .data_i (shaped_data),
            .len_i  (st_q.ctrl.len),
            .crc_o  (lane_res[g])
        );
    end

    mpcrc_out_shape #(.DW(DW)) u_out (
        .raw_i  (st_q.crc),
        .mode_i (st_q.ctrl.mode),
        .rev_i  (st_q.ctrl.out_rev),
        .inv_i  (st_q.ctrl.out_inv),
        .sum_o  (checksum_o)
    );

    assign wr_ctrl = decode_ctrl(wr_data);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (port_sel_e'(wr_sel))
                SEL_CTRL: begin
                    st_d.ctrl = wr_ctrl;
                    if (wr_data[1]) begin
                        st_d.crc = st_q.seed & mode_mask(wr_ctrl.mode);
                    end
                end
                SEL_DATA: begin
                    if (st_q.ctrl.en) begin
                        st_d.crc = lane_res[st_q.ctrl.mode];
                    end
                end
                SEL_SEED: st_d.seed = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (port_sel_e'(rd_sel))
            SEL_CTRL: rd_data = {{(DW-10){1'b0}}, st_q.ctrl.mode, st_q.ctrl.len, st_q.ctrl.out_inv,
                                 st_q.ctrl.in_inv, st_q.ctrl.out_rev, st_q.ctrl.in_rev, 1'b0, st_q.ctrl.en};
            SEL_DATA: rd_data = checksum_o;
            SEL_SEED: rd_data = st_q.seed;
            default:  rd_data = '0;
        endcase
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DATA && !st_q.ctrl.en) |=> $stable(checksum_o)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(checksum_o)); // R9

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && wr_data[1] && !wr_data[3] && !wr_data[5])
        |=> checksum_o == ($past(st_q.seed) & mode_mask(crc_mode_e'($past(wr_data[9:8]))))); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode != MODE_C32) |-> (checksum_o[DW-1:16] == '0)); // R6

    AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode == MODE_C8) |-> (checksum_o[DW-1:8] == '0)); // R6
endmodule

// File: tb/sim_multipoly_crc.sv
`timescale 1ns/1ps
module sim_multipoly_crc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [31:0] checksum_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit cmp_on = 0;

    logic [31:0] m_ctrl, m_seed, m_crc;

    always #2.5 clk = ~clk;

    multipoly_crc u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .checksum_o(checksum_o)
    );

    function automatic int width_of(logic [1:0] m);
        return (m == 2'd1) ? 8 : (m == 2'd3) ? 32 : 16;
    endfunction

    function automatic logic [31:0] poly_of(logic [1:0] m);
        case (m)
            2'd0: return 32'h1021;
            2'd1: return 32'h07;
            2'd2: return 32'h8005;
            default: return 32'h04C11DB7;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(logic [1:0] m);
        int w = width_of(m);
        return (w == 32) ? 32'hFFFFFFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic logic [31:0] model_out(logic [31:0] crc, logic [31:0] c);
        int w = width_of(c[9:8]);
        logic [31:0] v = crc & mask_of(c[9:8]);
        logic [31:0] r = '0;
        if (c[3]) begin
            for (int i = 0; i < w; i++) r[i] = v[w-1-i];
            v = r;
        end
        if (c[5]) v = ~v & mask_of(c[9:8]);
        return v;
    endfunction

    function automatic logic [31:0] model_step(logic [31:0] crc, logic [31:0] c, logic [31:0] d);
        int w = width_of(c[9:8]);
        int n = (c[7:6] == 2'd0) ? 8 : (c[7:6] == 2'd1) ? 16 : 32;
        logic [31:0] x = d;
        logic [31:0] p = poly_of(c[9:8]);
        logic [31:0] v = crc & mask_of(c[9:8]);
        if (c[2]) for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) x[b*8+i] = d[b*8+7-i];
        if (c[4]) x = ~x;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = v[w-1] ^ x[i];
            v = (v << 1) & mask_of(c[9:8]);
            if (fb) v = v ^ p;
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_seed = '0; m_crc = '0;
        end else if (wr_en) begin
            case (wr_sel)
                2'd0: begin
                    m_ctrl = wr_data & 32'h3FD;
                    if (wr_data[1]) m_crc = m_seed & mask_of(wr_data[9:8]);
                end
                2'd1: if (m_ctrl[0]) m_crc = model_step(m_crc, m_ctrl, wr_data);
                2'd2: m_seed = wr_data;
                default: ;
            endcase
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) check("R9 per-cycle model", checksum_o, model_out(m_crc, m_ctrl));
    end

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    function automatic logic [31:0] mk(bit en, bit rst, bit irev, bit orev, bit iinv, bit oinv,
                                       logic [1:0] len, logic [1:0] mode);
        return {22'd0, mode, len, oinv, iinv, orev, irev, rst, en};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] a, hold;
        logic [31:0] kat [4];
        kat[0] = 32'h1021; kat[1] = 32'h07; kat[2] = 32'h8005; kat[3] = 32'h04C11DB7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 checksum", checksum_o, 32'h0);
        rd_sel = 2'd0; #0.1; check("R10 ctrl", rd_data, 32'h0);
        rd_sel = 2'd2; #0.1; check("R10 seed", rd_data, 32'h0);
        cmp_on = 1;

        // R1 known answers per polynomial
        for (int m = 0; m < 4; m++) begin
            wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd2, 2'(m)));
            wr(2'd1, 32'h1);
            check("R1 polynomial", checksum_o, kat[m]);
        end

        // R2 widths
        wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd0, 2'd3)); wr(2'd1, 32'hFFFFFF01);
        check("R2 8-bit", checksum_o, 32'h04C11DB7);
        wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd1, 2'd3)); wr(2'd1, 32'hABCD0001);
        check("R2 16-bit", checksum_o, 32'h04C11DB7);
        wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd3, 2'd3)); wr(2'd1, 32'h00000001);
        check("R2 reserved as 32", checksum_o, 32'h04C11DB7);
        wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd3, 2'd3)); wr(2'd1, 32'h00010000);
        check("R2 reserved upper used", checksum_o, model_step(32'h0, mk(1,0,0,0,0,0,2'd2,2'd3), 32'h00010000));

        // R3 per-byte input reversal
        wr(2'd0, mk(1, 1, 1, 0, 0, 0, 2'd2, 2'd3)); wr(2'd1, 32'hAABBCCDD);
        a = checksum_o;
        wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd2, 2'd3)); wr(2'd1, 32'h55DD33BB);
        check("R3 byte reversal", a, checksum_o);

        // R4 input inversion
        wr(2'd0, mk(1, 1, 0, 0, 1, 0, 2'd2, 2'd3)); wr(2'd1, 32'hFFFFFFFE);
        check("R4 input inversion", checksum_o, 32'h04C11DB7);

        // R5 output reversal
        wr(2'd0, mk(1, 1, 0, 1, 0, 0, 2'd2, 2'd3)); wr(2'd1, 32'h1);
        check("R5 reverse 32", checksum_o, 32'hEDB88320);
        wr(2'd0, mk(1, 1, 0, 1, 0, 0, 2'd0, 2'd1)); wr(2'd1, 32'h1);
        check("R5 reverse 8", checksum_o, 32'h000000E0);

        // R6 output inversion and zero upper bits
        wr(2'd0, mk(1, 1, 0, 0, 0, 1, 2'd2, 2'd3)); wr(2'd1, 32'h1);
        check("R6 invert 32", checksum_o, 32'hFB3EE248);
        wr(2'd0, mk(1, 1, 0, 0, 0, 1, 2'd0, 2'd1)); wr(2'd1, 32'h1);
        check("R6 invert 8", checksum_o, 32'h000000F8);

        // R7 seed reload and self-clearing bit
        wr(2'd2, 32'h12345678);
        wr(2'd0, mk(1, 1, 0, 0, 0, 0, 2'd1, 2'd2));
        check("R7 seed load", checksum_o, 32'h00005678);
        rd_sel = 2'd0; #0.1;
        check("R7 ctrl readback", rd_data, mk(1, 0, 0, 0, 0, 0, 2'd1, 2'd2));
        rd_sel = 2'd1; #0.1;
        check("R7 read port checksum", rd_data, 32'h00005678);

        // R8 disabled engine ignores data
        wr(2'd0, mk(0, 0, 0, 0, 0, 0, 2'd1, 2'd2));
        wr(2'd1, 32'hDEADBEEF);
        check("R8 ignored write", checksum_o, 32'h00005678);

        // R9 one-cycle update and idle stability
        wr(2'd0, mk(1, 0, 0, 0, 0, 0, 2'd1, 2'd2));
        wr(2'd1, 32'h0000BEEF);
        check("R9 next-edge update", checksum_o, model_step(32'h5678, mk(1,0,0,0,0,0,2'd1,2'd2), 32'h0000BEEF));
        hold = checksum_o;
        repeat (5) @(negedge clk);
        check("R9 idle stable", checksum_o, hold);

        // Random sweep over all modes, widths and transforms (R1-R7)
        for (int it = 0; it < 600; it++) begin
            int k = $urandom_range(0, 9);
            if (k == 0) wr(2'd2, $urandom());
            else if (k <= 2) wr(2'd0, ($urandom() & 32'h3FE) | 32'h1);
            else if (k == 3) wr(2'd0, $urandom() & 32'h3FF);
            else wr(2'd1, $urandom());
            if (it % 50 == 0) check("R1 R2 R3 R4 R5 R6 sweep", checksum_o, model_out(m_crc, m_ctrl));
        end

        cmp_on = 0;
        finish_run();
    end
endmodule